// File: doc/BRIEF.md
# Grouped Interrupt Expander with Per-Group Acknowledge Lock

This block gathers a large set of peripheral interrupt requests into a handful of groups, with one CPU interrupt input per group. Every source has its own flag bit, set on a rising edge of its request line, and its own enable bit. A group whose acknowledge bit is clear sends the CPU a single-cycle pulse as soon as any of its sources is both flagged and enabled. Sending the pulse sets the group's acknowledge bit, which locks the group. While the lock is set, no further pulses leave that group, even if more of its sources become flagged.

Software releases a group by writing 1 to its acknowledge bit. If an enabled, flagged source is still waiting in that group, a fresh pulse follows at once. When the CPU takes an interrupt, it presents the group number on the fetch port. If vector fetching is switched on, the block returns the index of the winning source and clears that source's flag. The winner is the lowest-numbered source that is both enabled and flagged. If vector fetching is switched off, the block reports no hit, so the CPU falls back to its own default vector, and no flag is changed.

Top module: `irq_group_expander`

## Requirements
- R1: After reset the control register, the acknowledge register, every enable register and every flag register read 0, and no group pulse or vector result is driven.
- R2: A 0-to-1 change on a source request sets that source's flag one cycle later, whether the source is enabled or not. A request that stays high does not set the flag again after software has cleared it.
- R3: When a group's acknowledge bit is 0 and at least one of its sources is both flagged and enabled, the block drives one single-cycle pulse on that group's output and sets its acknowledge bit (bit g of the acknowledge register at address 0x01, for group g counted from 0).
- R4: While a group's acknowledge bit is 1, that group sends no pulse, even when more of its sources become flagged.
- R5: Writing 1 to an acknowledge bit clears it, and if the group still has an enabled, flagged source a new pulse follows. Writing 0 to the bit leaves it unchanged.
- R6: Groups work independently of each other: a lock or a pulse in one group has no effect on any other group, up to the last group, number 11.
- R7: When vector enable (bit 0 of the control register at address 0x00) is 1, a fetch for group g reports a hit one cycle later. The reported index is g*8+s, where s is the lowest-numbered source that is both enabled and flagged, and that source's flag is cleared. Flagged sources that are disabled do not compete.
- R8: When vector enable is 0, a fetch reports a valid result with no hit and index 0, and leaves every flag unchanged.
- R9: A fetch for a group that has no enabled, flagged source reports no hit and index 0.
- R10: The enable register of group g is at address 0x20+g and its flag register at 0x40+g. Source s is bit s in both. A write replaces the register's contents, except that a request edge in the same cycle still sets its flag. A read returns the addressed register one cycle after the read strobe.
- R11: A flagged source whose enable bit is 0 causes no pulse. Setting its enable bit later produces a pulse if the group is not locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | NUM_GROUPS*SRC_PER_GROUP | Source request lines; bit g*8+s is source s of group g |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, one cycle after the read strobe |
| fetch_req | input | 1 | CPU vector fetch strobe |
| fetch_grp | input | GRP_W | Group being serviced |
| irq_pulse | output | NUM_GROUPS | One-cycle interrupt pulse per group |
| vec_valid | output | 1 | Fetch result valid |
| vec_hit | output | 1 | A source vector was produced |
| vec_idx | output | VEC_W | Index of the winning source |

## Verification
The bench first flags a source while it is disabled. A design that pulses on flags alone, or that gates the flag with the enable, is caught here. Next it flags a second source inside a locked group and checks that the pulse count does not change; a design that does not hold the lock sends an extra pulse. It writes 0 and then 1 to the acknowledge bit while a source is still pending. A design that re-arms on any write, or that needs a fresh request edge before pulsing again, gets the wrong count. Finally it fetches when several sources are flagged, including a disabled lower-numbered source in the last group, and fetches again with vector enable off. A wrong priority order, a missing flag clear, or a flag cleared on a default fetch all show up as a wrong index or wrong flag contents.

// File: rtl/irqx_pkg.sv
package irqx_pkg;

  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] ADDR_CTRL      = 8'h00;
  localparam logic [ADDR_W-1:0] ADDR_ACK       = 8'h01;
  localparam logic [ADDR_W-1:0] ADDR_EN_BASE   = 8'h20;
  localparam logic [ADDR_W-1:0] ADDR_FLAG_BASE = 8'h40;
  localparam int MAX_SRC = 32;

  // Index of the least significant set bit (0 when none is set).
  function automatic logic [4:0] lowest_set(input logic [MAX_SRC-1:0] v);
    logic [4:0] r;
    r = '0;
    for (int i = MAX_SRC - 1; i >= 0; i--) begin
      if (v[i]) r = 5'(i);
    end
    return r;
  endfunction

endpackage

// File: rtl/irqx_group.sv
module irqx_group
  import irqx_pkg::*;
#(
  parameter int SRC = 8,
  parameter int SW  = (SRC > 1) ? $clog2(SRC) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SRC-1:0] req_i,
  input  logic          en_wr_i,
  input  logic          flag_wr_i,
  input  logic [SRC-1:0] wdata_i,
  input  logic          ack_clr_i,
  input  logic          fetch_i,
  output logic [SRC-1:0] en_o,
  output logic [SRC-1:0] flag_o,
  output logic          ack_o,
  output logic          pulse_o,
  output logic          win_valid_o,
  output logic [SW-1:0] win_idx_o
);

  logic [SRC-1:0] req_q, en_q, flag_q;
  logic           ack_q, pulse_q;
  logic [SRC-1:0] edge_set, active, clr_mask, flag_d;
  logic [4:0]     low_idx;
  logic           fire;

  assign edge_set = req_i & ~req_q;
  assign active   = flag_q & en_q;
  assign low_idx  = lowest_set(MAX_SRC'(active));
  assign win_valid_o = |active;
  assign win_idx_o   = low_idx[SW-1:0];

  always_comb begin
    clr_mask = '0;
    if (fetch_i && win_valid_o) clr_mask[win_idx_o] = 1'b1;
    flag_d = ((flag_wr_i ? wdata_i : flag_q) & ~clr_mask) | edge_set;
  end

  assign fire = win_valid_o && !ack_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q   <= '0;
      en_q    <= '0;
      flag_q  <= '0;
      ack_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      req_q   <= req_i;
      if (en_wr_i) en_q <= wdata_i;
      flag_q  <= flag_d;
      ack_q   <= ack_q ? !ack_clr_i : fire;
      pulse_q <= fire;
    end
  end

  assign en_o    = en_q;
  assign flag_o  = flag_q;
  assign ack_o   = ack_q;
  assign pulse_o = pulse_q;

  // R3: a pulse lasts exactly one cycle
  a_r3_single_cycle: assert property (@(posedge clk) disable iff (rst)
    pulse_q |=> !pulse_q);
  // R3: a pulse leaves the group locked
  a_r3_pulse_locks: assert property (@(posedge clk) disable iff (rst)
    pulse_q |-> ack_q);
  // R4: a locked group that is not released sends nothing
  a_r4_locked_quiet: assert property (@(posedge clk) disable iff (rst)
    (ack_q && !ack_clr_i) |=> !pulse_q);
  // R2: a request edge always leaves its flag set
  a_r2_edge_sets: assert property (@(posedge clk) disable iff (rst)
    (|edge_set) |=> ((flag_q & $past(edge_set)) == $past(edge_set)));
  // R7: a fetch clears at most one flag
  a_r7_clear_one: assert property (@(posedge clk) disable iff (rst)
    $onehot0(clr_mask));

endmodule

// File: rtl/irqx_regif.sv
module irqx_regif
  import irqx_pkg::*;
#(
  parameter int GRP    = 12,
  parameter int SRC    = 8,
  parameter int ACK_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_i,
  input  logic                   rd_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  input  logic [GRP-1:0][SRC-1:0] en_i,
  input  logic [GRP-1:0][SRC-1:0] flag_i,
  input  logic [GRP-1:0]         ack_i,
  output logic                   ctrl_o,
  output logic [GRP-1:0]         en_wr_o,
  output logic [GRP-1:0]         flag_wr_o,
  output logic [GRP-1:0]         ack_clr_o,
  output logic [DATA_W-1:0]      rdata_o
);

  logic              ctrl_q;
  logic [DATA_W-1:0] rd_q, rd_d;
  logic [ACK_W-1:0]  ack_view;

  for (genvar g = 0; g < GRP; g++) begin : g_dec
    assign en_wr_o[g]   = wr_i && (addr_i == ADDR_W'(ADDR_EN_BASE + g));
    assign flag_wr_o[g] = wr_i && (addr_i == ADDR_W'(ADDR_FLAG_BASE + g));
    assign ack_clr_o[g] = wr_i && (addr_i == ADDR_ACK) && wdata_i[g];
  end

  assign ack_view = ACK_W'(ack_i);

  always_comb begin
    rd_d = '0;
    if (addr_i == ADDR_CTRL) rd_d[0] = ctrl_q;
    if (addr_i == ADDR_ACK)  rd_d    = DATA_W'(ack_view);
    for (int g = 0; g < GRP; g++) begin
      if (addr_i == ADDR_W'(ADDR_EN_BASE + g))   rd_d = DATA_W'(en_i[g]);
      if (addr_i == ADDR_W'(ADDR_FLAG_BASE + g)) rd_d = DATA_W'(flag_i[g]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= 1'b0;
      rd_q   <= '0;
    end else begin
      if (wr_i && addr_i == ADDR_CTRL) ctrl_q <= wdata_i[0];
      if (rd_i) rd_q <= rd_d;
    end
  end

  assign ctrl_o  = ctrl_q;
  assign rdata_o = rd_q;

  // R5: an acknowledge write clears at most the groups whose data bit is 1
  a_r5_clr_from_data: assert property (@(posedge clk) disable iff (rst)
    (ack_clr_o & ~wdata_i[GRP-1:0]) == '0);

endmodule

// File: rtl/irq_group_expander.sv
module irq_group_expander
  import irqx_pkg::*;
#(
  parameter int NUM_GROUPS    = 12,
  parameter int SRC_PER_GROUP = 8,
  parameter int ACK_W         = 16,
  parameter int DATA_W        = 16,
  localparam int GRP_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  localparam int SRC_W = (SRC_PER_GROUP > 1) ? $clog2(SRC_PER_GROUP) : 1,
  localparam int VEC_W = $clog2(NUM_GROUPS * SRC_PER_GROUP)
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic [NUM_GROUPS*SRC_PER_GROUP-1:0]   src_req,
  input  logic                                  reg_wr,
  input  logic                                  reg_rd,
  input  logic [ADDR_W-1:0]                     reg_addr,
  input  logic [DATA_W-1:0]                     reg_wdata,
  output logic [DATA_W-1:0]                     reg_rdata,
  input  logic                                  fetch_req,
  input  logic [GRP_W-1:0]                      fetch_grp,
  output logic [NUM_GROUPS-1:0]                 irq_pulse,
  output logic                                  vec_valid,
  output logic                                  vec_hit,
  output logic [VEC_W-1:0]                      vec_idx
);

  logic [NUM_GROUPS-1:0][SRC_PER_GROUP-1:0] en_all, flag_all;
  logic [NUM_GROUPS-1:0]                    ack_all, en_wr, flag_wr, ack_clr;
  logic [NUM_GROUPS-1:0]                    win_valid, grp_fetch;
  logic [SRC_W-1:0]                         win_idx [NUM_GROUPS];
  logic                                     ctrl_en;
  logic                                     sel_valid;
  logic [SRC_W-1:0]                         sel_idx;
  logic                                     vvalid_q, vhit_q;
  logic [VEC_W-1:0]                         vidx_q;

  irqx_regif #(
    .GRP(NUM_GROUPS), .SRC(SRC_PER_GROUP), .ACK_W(ACK_W), .DATA_W(DATA_W)
  ) u_regif (
    .clk(clk), .rst(rst), .wr_i(reg_wr), .rd_i(reg_rd), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .en_i(en_all), .flag_i(flag_all), .ack_i(ack_all),
    .ctrl_o(ctrl_en), .en_wr_o(en_wr), .flag_wr_o(flag_wr),
    .ack_clr_o(ack_clr), .rdata_o(reg_rdata)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    assign grp_fetch[g] = fetch_req && ctrl_en && (fetch_grp == GRP_W'(g));

    irqx_group #(.SRC(SRC_PER_GROUP), .SW(SRC_W)) u_grp (
      .clk(clk), .rst(rst),
      .req_i(src_req[g*SRC_PER_GROUP +: SRC_PER_GROUP]),
      .en_wr_i(en_wr[g]), .flag_wr_i(flag_wr[g]),
      .wdata_i(reg_wdata[SRC_PER_GROUP-1:0]),
      .ack_clr_i(ack_clr[g]), .fetch_i(grp_fetch[g]),
      .en_o(en_all[g]), .flag_o(flag_all[g]), .ack_o(ack_all[g]),
      .pulse_o(irq_pulse[g]), .win_valid_o(win_valid[g]),
      .win_idx_o(win_idx[g])
    );
  end

  always_comb begin
    sel_valid = 1'b0;
    sel_idx   = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (fetch_grp == GRP_W'(g)) begin
        sel_valid = win_valid[g];
        sel_idx   = win_idx[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vvalid_q <= 1'b0;
      vhit_q   <= 1'b0;
      vidx_q   <= '0;
    end else begin
      vvalid_q <= fetch_req;
      vhit_q   <= fetch_req && ctrl_en && sel_valid;
      vidx_q   <= (fetch_req && ctrl_en && sel_valid)
                  ? VEC_W'(VEC_W'(fetch_grp) * VEC_W'(SRC_PER_GROUP) + VEC_W'(sel_idx))
                  : '0;
    end
  end

  assign vec_valid = vvalid_q;
  assign vec_hit   = vhit_q;
  assign vec_idx   = vidx_q;

  // R8: with vector enable off a fetch never hits
  a_r8_default_no_hit: assert property (@(posedge clk) disable iff (rst)
    (fetch_req && !ctrl_en) |=> (vec_valid && !vec_hit));
  // R9: a result without a hit carries index 0
  a_r9_miss_zero: assert property (@(posedge clk) disable iff (rst)
    (vec_valid && !vec_hit) |-> (vec_idx == '0));
  // R7: a hit only answers a fetch
  a_r7_hit_needs_fetch: assert property (@(posedge clk) disable iff (rst)
    vec_hit |-> vec_valid);

endmodule

// File: tb/irq_group_expander_bench.sv
module irq_group_expander_bench;

  localparam int G = 12;
  localparam int S = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [G*S-1:0] src_req = '0;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]    reg_addr = '0;
  logic [15:0]   reg_wdata = '0;
  logic [15:0]   reg_rdata;
  logic          fetch_req = 1'b0;
  logic [3:0]    fetch_grp = '0;
  logic [G-1:0]  irq_pulse;
  logic          vec_valid, vec_hit;
  logic [6:0]    vec_idx;

  int tests = 0, fails = 0;
  bit done = 0;
  int pc [G];

  always #10 clk = ~clk;

  irq_group_expander u_irq_group_expander (
    .clk(clk), .rst(rst), .src_req(src_req), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .fetch_req(fetch_req), .fetch_grp(fetch_grp), .irq_pulse(irq_pulse),
    .vec_valid(vec_valid), .vec_hit(vec_hit), .vec_idx(vec_idx)
  );

  always @(posedge clk) begin
    for (int i = 0; i < G; i++) pc[i] <= rst ? 0 : pc[i] + int'(irq_pulse[i]);
  end

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input int exp);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0;
    chk(tag, int'(reg_rdata), exp);
  endtask

  task automatic fetch_chk(input string tag, input int grp, input int hit, input int idx);
    @(negedge clk); fetch_req = 1'b1; fetch_grp = 4'(grp);
    @(negedge clk); fetch_req = 1'b0;
    chk({tag, " valid"}, int'(vec_valid), 1);
    chk({tag, " hit"}, int'(vec_hit), hit);
    chk({tag, " idx"}, int'(vec_idx), idx);
  endtask

  task automatic raise(input int g, input int s);
    @(negedge clk); src_req[g*S+s] = 1'b1;
  endtask

  task automatic t_reset;
    rd_chk("R1 ctrl", 8'h00, 0);
    rd_chk("R1 ack", 8'h01, 0);
    rd_chk("R1 en g0", 8'h20, 0);
    rd_chk("R1 flag g11", 8'h4B, 0);
    chk("R1 pulses g0", pc[0], 0);
    chk("R1 vec_valid", int'(vec_valid), 0);
  endtask

  task automatic t_flag_disabled;
    raise(0, 3);
    idle(4);
    rd_chk("R2 flag set while disabled", 8'h40, 8'h08);
    chk("R11 no pulse while disabled", pc[0], 0);
    wr(8'h40, 16'h0000);
    idle(3);
    rd_chk("R2 held request no reset of flag", 8'h40, 0);
    @(negedge clk); src_req[3] = 1'b0;
    raise(0, 3);
    idle(2);
    rd_chk("R2 new edge sets flag", 8'h40, 8'h08);
  endtask

  task automatic t_lock_and_ack;
    wr(8'h20, 16'h00FF);
    idle(4);
    chk("R11 enable later pulses", pc[0], 1);
    rd_chk("R3 ack locked", 8'h01, 1);
    raise(0, 5);
    idle(4);
    chk("R4 no pulse while locked", pc[0], 1);
    wr(8'h01, 16'h0000);
    idle(3);
    chk("R5 write 0 no pulse", pc[0], 1);
    rd_chk("R5 write 0 keeps ack", 8'h01, 1);
    wr(8'h01, 16'h0001);
    idle(4);
    chk("R5 pending repulse", pc[0], 2);
    rd_chk("R5 relocked", 8'h01, 1);
  endtask

  task automatic t_fetch;
    wr(8'h00, 16'h0001);
    fetch_chk("R7 lowest first", 0, 1, 3);
    rd_chk("R7 flag cleared", 8'h40, 8'h20);
    fetch_chk("R7 next source", 0, 1, 5);
    fetch_chk("R9 empty group", 0, 0, 0);
  endtask

  task automatic t_default_and_groups;
    wr(8'h00, 16'h0000);
    wr(8'h22, 16'h0002);
    raise(2, 1);
    idle(4);
    chk("R6 group 2 pulses", pc[2], 1);
    chk("R6 group 0 untouched", pc[0], 2);
    fetch_chk("R8 default vector", 2, 0, 0);
    rd_chk("R8 flag kept", 8'h42, 8'h02);
    wr(8'h2B, 16'h0040);
    raise(11, 0);
    raise(11, 6);
    idle(4);
    chk("R6 last group pulses", pc[11], 1);
    rd_chk("R6 ack per group", 8'h01, 16'h0805);
    wr(8'h00, 16'h0001);
    fetch_chk("R7 disabled lower source skipped", 11, 1, 94);
    rd_chk("R7 only winner cleared", 8'h4B, 8'h01);
  endtask

  task automatic t_flag_write;
    wr(8'h44, 16'h0081);
    rd_chk("R10 flag write", 8'h44, 8'h81);
    wr(8'h24, 16'h0003);
    rd_chk("R10 enable write", 8'h24, 8'h03);
    idle(3);
    chk("R10 written flag pulses", pc[4], 1);
  endtask

  initial begin
    idle(4);
    rst = 1'b0;
    idle(2);
    t_reset;
    t_flag_disabled;
    t_lock_and_ack;
    t_fetch;
    t_default_and_groups;
    t_flag_write;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule